// File: doc/BRIEF.md
# Dual Match Timer with Crossing-Status Flags

This block holds two up-counting match timers. They count on a slow timer clock. Software programs them through a register window that runs on a faster bus clock. Every bus write to a timer's match, enable or clear register is recorded on the bus side first. It is then carried into the timer clock domain by a toggle handshake.

A shared status word shows, per timer:

- the enable and clear-on-match bits last written, and
- whether a configuration write or a clear is still in flight.

Software polls these flags before relying on the new settings. When a running counter equals its match value, the timer drives a level interrupt in the timer clock domain. With clear-on-match set, the counter then restarts from zero, which gives a periodic tick. Without it, the counter runs on and wraps at all ones. A count read returns a whole snapshot taken in the timer domain, so its bits always belong to one count value.

The bus uses word addresses. The byte offsets below are four times the word index.

Top module: `dual_match_timer`

## Requirements
- R1: After reset, every count is zero, every timer is stopped, the status word reads zero, match values read back zero and all interrupts are low.
- R2: Timer i occupies word addresses 4i to 4i+3: match (byte offset 0x0), count (0x4), enable (0x8) and clear (0xC). Match and enable read back the value last accepted. Clear reads zero.
- R3: The status word sits at word address 4×NUM_TIMERS. Timer i uses bits [8i+7:8i], laid out as follows:
  - bit 0 is the written run bit;
  - bit 1 is the written clear-on-match bit;
  - bit 2 is clear-pending;
  - bit 3 is write-pending.
- R4: An accepted write to match or enable raises write-pending on the next bus clock edge. The flag falls once the timer domain has applied the write, within a few timer clocks.
- R5: A write to match or enable while that timer's write-pending is high is dropped, and so is a write to clear while its clear-pending is high.
- R6: Writing any value to clear raises clear-pending. The timer's count becomes zero before clear-pending falls.
- R7: In the enable register, bit 0 runs the counter and bit 1 selects clear-on-match. A running counter with clear-on-match counts 0 up to match and back to 0, so its match events repeat every match+1 timer clocks.
- R8: A running counter with clear-on-match off passes match and wraps at all ones, so its match events repeat every 2^CNT_W timer clocks.
- R9: The interrupt of timer i is high exactly while timer i runs and its count equals its match value. It is low whenever the timer is stopped.
- R10: A stopped counter holds its value. Reads of count return an untorn snapshot of it.
- R11: The two timers are independent: activity on one leaves the other's count and interrupt unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus register clock |
| tmr_clk | input | 1 | Slow timer clock |
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| bus_addr | input | ADDR_W | Word address of the access |
| bus_we | input | 1 | Write strobe, one bus clock per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | NUM_TIMERS | Per-timer match interrupt, timer clock domain |

## Verification
The bench measures the spacing between interrupt pulses in timer clocks. It expects match+1 with clear-on-match and 2^CNT_W without. An off-by-one compare or a missing wrap shifts that spacing.

It issues a second match write while the first is still crossing. A design that accepts it would corrupt the value being loaded, and the readback would show the second value.

It reads write-pending on the very next bus cycle after a write and reads clear-pending right after a clear. A design that sets a flag late, or never, fails there.

It stops a counter and compares two count reads taken far apart. It clears the counter and reads zero. It confirms that the other timer's running does not disturb it.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

    localparam int DATA_W      = 32;
    localparam int WORDS_PER_T = 4;
    localparam int LANE_W      = 8;

    typedef enum logic [1:0] {
        REG_MATCH  = 2'd0,
        REG_COUNT  = 2'd1,
        REG_ENABLE = 2'd2,
        REG_CLEAR  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic com;   // clear count when it equals match
        logic run;   // counter advances
    } ctl_t;

    function automatic logic [LANE_W-1:0] status_lane(ctl_t c, logic clr_p, logic wr_p);
        return {4'b0000, wr_p, clr_p, c.com, c.run};
    endfunction

endpackage

// File: rtl/dmt_sync.sv
module dmt_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dmt_bus_side.sv
module dmt_bus_side
    import dmt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_match,
    input  logic              wr_enable,
    input  logic              wr_clear,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_ack_tgl,
    input  logic              clr_ack_tgl,
    input  logic              snap_tgl,
    input  logic [CNT_W-1:0]  snap_hold,
    output logic [CNT_W-1:0]  match_sh,
    output ctl_t              ctl_sh,
    output logic              wr_tgl,
    output logic              clr_tgl,
    output logic              snap_ack,
    output logic [CNT_W-1:0]  cnt_rd,
    output logic              wr_pend,
    output logic              clr_pend
);
    logic wr_ack_s, clr_ack_s, snap_s;

    dmt_sync #(.W(3)) ack_sync_i (
        .clk(clk), .rst(rst),
        .d({wr_ack_tgl, clr_ack_tgl, snap_tgl}),
        .q({wr_ack_s, clr_ack_s, snap_s})
    );

    assign wr_pend  = wr_tgl ^ wr_ack_s;
    assign clr_pend = clr_tgl ^ clr_ack_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            match_sh <= '0;
            ctl_sh   <= '0;
            wr_tgl   <= 1'b0;
            clr_tgl  <= 1'b0;
            snap_ack <= 1'b0;
            cnt_rd   <= '0;
        end else begin
            if ((wr_match || wr_enable) && !wr_pend) begin
                if (wr_match)  match_sh <= wdata[CNT_W-1:0];
                if (wr_enable) ctl_sh   <= ctl_t'(wdata[1:0]);
                wr_tgl <= ~wr_tgl;
            end
            if (wr_clear && !clr_pend) clr_tgl <= ~clr_tgl;
            // hold register is frozen until snap_ack returns to the timer side
            if (snap_s != snap_ack) begin
                cnt_rd   <= snap_hold;
                snap_ack <= snap_s;
            end
        end
    end

    // R4
    wr_pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        ((wr_match || wr_enable) && !wr_pend) |=> wr_pend);
    // R5
    wr_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_pend && (wr_match || wr_enable)) |=> ($stable(match_sh) && $stable(ctl_sh)));
    // R6
    clr_pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_clear && !clr_pend) |=> clr_pend);
endmodule

// File: rtl/dmt_core.sv
module dmt_core
    import dmt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] match_sh,
    input  ctl_t             ctl_sh,
    input  logic             wr_tgl,
    input  logic             clr_tgl,
    input  logic             snap_ack,
    output logic             wr_ack_tgl,
    output logic             clr_ack_tgl,
    output logic             snap_tgl,
    output logic [CNT_W-1:0] snap_hold,
    output logic             irq
);
    logic             wr_s, clr_s, ack_s;
    logic             wr_d, clr_d;
    logic [CNT_W-1:0] match_q, cnt, cnt_inc;
    ctl_t             ctl_q;
    logic             ld_evt, clr_evt, at_match;

    dmt_sync #(.W(3)) req_sync_i (
        .clk(clk), .rst(rst),
        .d({wr_tgl, clr_tgl, snap_ack}),
        .q({wr_s, clr_s, ack_s})
    );

    assign ld_evt      = wr_s ^ wr_d;
    assign clr_evt     = clr_s ^ clr_d;
    assign wr_ack_tgl  = wr_d;
    assign clr_ack_tgl = clr_d;
    assign at_match    = (cnt == match_q);
    assign cnt_inc     = cnt + 1'b1;
    assign irq         = ctl_q.run && at_match;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_d      <= 1'b0;
            clr_d     <= 1'b0;
            match_q   <= '0;
            ctl_q     <= '0;
            cnt       <= '0;
            snap_tgl  <= 1'b0;
            snap_hold <= '0;
        end else begin
            wr_d  <= wr_s;
            clr_d <= clr_s;
            if (ld_evt) begin
                match_q <= match_sh;
                ctl_q   <= ctl_sh;
            end
            if (clr_evt)                        cnt <= '0;
            else if (ctl_q.run && ctl_q.com && at_match) cnt <= '0;
            else if (ctl_q.run)                 cnt <= cnt_inc;
            if (snap_tgl == ack_s) begin
                snap_hold <= cnt;
                snap_tgl  <= ~snap_tgl;
            end
        end
    end

    // R6
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr_evt |=> (cnt == '0));
    // R7
    com_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.run && ctl_q.com && at_match) |=> (cnt == '0));
    // R8
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.run && !clr_evt && !(ctl_q.com && at_match)) |=> (cnt == $past(cnt_inc)));
    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q.run && !clr_evt) |=> $stable(cnt));
    // R10
    snap_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (snap_tgl != ack_s) |=> $stable(snap_hold));
endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer
    import dmt_pkg::*;
#(
    parameter int NUM_TIMERS = 2,
    parameter int CNT_W      = 32,
    parameter int ADDR_W     = $clog2(NUM_TIMERS * WORDS_PER_T + 1)
) (
    input  logic                  bus_clk,
    input  logic                  tmr_clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_we,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic [NUM_TIMERS-1:0] irq
);
    localparam int TSEL_W      = ADDR_W - 2;
    localparam int STATUS_WORD = NUM_TIMERS * WORDS_PER_T;

    logic [CNT_W-1:0] match_sh [NUM_TIMERS];
    logic [CNT_W-1:0] cnt_rd   [NUM_TIMERS];
    ctl_t             ctl_sh   [NUM_TIMERS];
    logic [NUM_TIMERS-1:0] wr_pend, clr_pend, hit;

    logic     is_status;
    reg_sel_e rsel;

    assign is_status = (bus_addr == ADDR_W'(STATUS_WORD));
    assign rsel      = reg_sel_e'(bus_addr[1:0]);

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
        logic             wr_tgl, clr_tgl, snap_ack;
        logic             wr_ack_tgl, clr_ack_tgl, snap_tgl;
        logic [CNT_W-1:0] snap_hold;

        assign hit[i] = !is_status && (bus_addr[ADDR_W-1:2] == TSEL_W'(i));

        dmt_bus_side #(.CNT_W(CNT_W)) bus_i (
            .clk(bus_clk), .rst(rst),
            .wr_match (bus_we && hit[i] && rsel == REG_MATCH),
            .wr_enable(bus_we && hit[i] && rsel == REG_ENABLE),
            .wr_clear (bus_we && hit[i] && rsel == REG_CLEAR),
            .wdata(bus_wdata),
            .wr_ack_tgl(wr_ack_tgl), .clr_ack_tgl(clr_ack_tgl),
            .snap_tgl(snap_tgl), .snap_hold(snap_hold),
            .match_sh(match_sh[i]), .ctl_sh(ctl_sh[i]),
            .wr_tgl(wr_tgl), .clr_tgl(clr_tgl), .snap_ack(snap_ack),
            .cnt_rd(cnt_rd[i]), .wr_pend(wr_pend[i]), .clr_pend(clr_pend[i])
        );

        dmt_core #(.CNT_W(CNT_W)) core_i (
            .clk(tmr_clk), .rst(rst),
            .match_sh(match_sh[i]), .ctl_sh(ctl_sh[i]),
            .wr_tgl(wr_tgl), .clr_tgl(clr_tgl), .snap_ack(snap_ack),
            .wr_ack_tgl(wr_ack_tgl), .clr_ack_tgl(clr_ack_tgl),
            .snap_tgl(snap_tgl), .snap_hold(snap_hold),
            .irq(irq[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_TIMERS; i++) begin
            if (is_status) begin
                bus_rdata[LANE_W*i +: LANE_W] = status_lane(ctl_sh[i], clr_pend[i], wr_pend[i]);
            end else if (hit[i]) begin
                unique case (rsel)
                    REG_MATCH:  bus_rdata = DATA_W'(match_sh[i]);
                    REG_COUNT:  bus_rdata = DATA_W'(cnt_rd[i]);
                    REG_ENABLE: bus_rdata = DATA_W'(ctl_sh[i]);
                    REG_CLEAR:  bus_rdata = '0;
                endcase
            end
        end
    end

    // R9
    irq_idle_chk: assert property (@(posedge tmr_clk) disable iff (rst)
        $past(rst) |-> (irq == '0));
endmodule

// File: tb/dual_match_timer_tb_top.sv
module dual_match_timer_tb_top;
    localparam int  BUS_PERIOD = 10;
    localparam int  TMR_PERIOD = 70;
    localparam int  NT         = 2;
    localparam int  CW         = 8;
    localparam int  AW         = 4;
    localparam logic [AW-1:0] STAT = 4'd8;

    logic          bus_clk = 1'b0, tmr_clk = 1'b0, rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NT-1:0] irq;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #(BUS_PERIOD/2) bus_clk = ~bus_clk;
    always #(TMR_PERIOD/2) tmr_clk = ~tmr_clk;

    dual_match_timer #(.NUM_TIMERS(NT), .CNT_W(CW), .ADDR_W(AW)) dut_i (
        .bus_clk(bus_clk), .tmr_clk(tmr_clk), .rst(rst),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [AW-1:0] waddr(int t, int r);
        return AW'(t * 4 + r);
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
        @(negedge bus_clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge bus_clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(logic [AW-1:0] a, output logic [31:0] d);
        @(negedge bus_clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle(int t, string req);
        logic [31:0] s;
        int n = 0;
        do begin
            bus_read(STAT, s);
            n++;
        end while (s[8*t+2 +: 2] != 2'b00 && n < 100);
        check(s[8*t+2 +: 2] == 2'b00, req, s[8*t+2 +: 2], 0);
    endtask

    task automatic tmr_wait(int n);
        repeat (n) @(negedge tmr_clk);
    endtask

    task automatic irq_period(int t, output int per);
        int n = 0;
        bit prev;
        per = -1;
        prev = irq[t];
        while (n < 2000 && !(irq[t] && !prev)) begin
            prev = irq[t]; @(negedge tmr_clk); n++;
        end
        n = 0; prev = irq[t];
        while (n < 2000) begin
            @(negedge tmr_clk); n++;
            if (irq[t] && !prev) begin per = n; break; end
            prev = irq[t];
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        bus_read(STAT, d);         check(d == 0, "R1", d, 0);
        bus_read(waddr(0, 1), d);  check(d == 0, "R1", d, 0);
        bus_read(waddr(1, 0), d);  check(d == 0, "R1", d, 0);
        check(irq == '0, "R1", irq, 0);
    endtask

    task automatic t_pending;
        logic [31:0] d;
        bus_write(waddr(0, 0), 32'd4);
        bus_read(STAT, d);         check(d[3] == 1'b1, "R4", d[3], 1);
        wait_idle(0, "R4");
        bus_read(waddr(0, 0), d);  check(d == 4, "R2", d, 4);
        bus_read(waddr(0, 3), d);  check(d == 0, "R2", d, 0);
    endtask

    task automatic t_drop;
        logic [31:0] d;
        bus_write(waddr(0, 0), 32'd7);
        bus_write(waddr(0, 0), 32'd9);
        bus_read(waddr(0, 0), d);  check(d == 7, "R5", d, 7);
        wait_idle(0, "R5");
        bus_read(waddr(0, 0), d);  check(d == 7, "R5", d, 7);
        bus_write(waddr(0, 0), 32'd4);
        wait_idle(0, "R5");
    endtask

    task automatic t_periodic;
        logic [31:0] d;
        int per;
        bus_write(waddr(0, 2), 32'd3);
        wait_idle(0, "R4");
        bus_read(STAT, d);         check(d[7:0] == 8'h03, "R3", d[7:0], 3);
        bus_read(waddr(0, 2), d);  check(d == 3, "R2", d, 3);
        irq_period(0, per);        check(per == 5, "R7", per, 5);
        for (int k = 0; k < 8; k++) begin
            tmr_wait(3);
            bus_read(waddr(0, 1), d);
            check(d <= 4, "R7", d, 4);
        end
    endtask

    task automatic t_wrap;
        logic [31:0] d;
        int per;
        bus_write(waddr(1, 0), 32'd3);
        wait_idle(1, "R4");
        bus_write(waddr(1, 2), 32'd1);
        wait_idle(1, "R4");
        bus_read(STAT, d);         check(d[15:8] == 8'h01, "R3", d[15:8], 1);
        irq_period(1, per);        check(per == 256, "R8", per, 256);
    endtask

    task automatic t_stop_clear;
        logic [31:0] a, b, s;
        bus_write(waddr(0, 2), 32'd0);
        wait_idle(0, "R9");
        tmr_wait(20);
        check(irq[0] == 1'b0, "R9", irq[0], 0);
        bus_read(waddr(0, 1), a);
        tmr_wait(15);
        bus_read(waddr(0, 1), b);  check(a == b, "R10", b, a);
        bus_write(waddr(0, 3), 32'hABCD);
        bus_read(STAT, s);         check(s[2] == 1'b1, "R6", s[2], 1);
        wait_idle(0, "R6");
        tmr_wait(20);
        bus_read(waddr(0, 1), a);  check(a == 0, "R6", a, 0);
    endtask

    task automatic t_indep;
        logic [31:0] a, b;
        tmr_wait(40);
        bus_read(waddr(0, 1), a);  check(a == 0, "R11", a, 0);
        check(irq[0] == 1'b0, "R11", irq[0], 0);
        bus_read(waddr(1, 1), a);
        tmr_wait(10);
        bus_read(waddr(1, 1), b);  check(a != b, "R11", b, a + 1);
    endtask

    initial begin
        repeat (6) @(negedge tmr_clk);
        rst = 1'b0;
        repeat (4) @(negedge tmr_clk);
        t_reset();
        t_pending();
        t_drop();
        t_periodic();
        t_wrap();
        t_stop_clear();
        t_indep();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #1500000;
                checks++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule